// File: doc/BRIEF.md
# Debug Breakpoint and Single-Step Trigger

This block decides, cycle by cycle, whether the core should be diverted into its debug handler. It watches the program-counter address, the execution context that is running, an instruction-retire strobe and an asynchronous break line. It raises a one-cycle trap request when an enabled trigger condition holds. There are three kinds of trigger. A single-step trigger can be armed separately for normal code and for each of the three interrupt levels. An address-match trigger compares the PC against a stored 20-bit breakpoint. A break trigger fires on a rising edge of an external, unsynchronized break line.

Software arms the triggers with one 32-bit command word on `cfg_wdata`, strobed by `cfg_we`. The same word also holds a mode bit that tells the port logic to return live pin states, not RAM contents. This block only stores that bit and presents it on `pin_read_mode`. While `in_handler` is high, no trap is issued. Step and address triggers that happen during that time are dropped. A captured break edge is kept pending and is delivered after the handler exits.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset, `trap_req` and `pin_read_mode` are 0, and no input activity produces a trap until a command word is written.
- R2: A write with `cfg_we` high takes effect at that clock edge. Command word bit 6 appears on `pin_read_mode` from the next cycle onward.
- R3: Single-step enable bits sit at word bits 0 (normal code, `exec_ctx`=0), 1 (level 1, `exec_ctx`=1), 2 (level 2, `exec_ctx`=2) and 3 (level 3, `exec_ctx`=3). A retire in a context whose bit is set gives `trap_req`=1 in the following cycle.
- R4: A retire in a context whose step bit is clear, or any cycle without a retire or a pending break, gives no trap.
- R5: When bit 4 is set, a retire while `pc_addr` equals word bits 27:8 gives `trap_req`=1 in the following cycle.
- R6: The address trap fires only once while `pc_addr` stays at the breakpoint. It is re-armed only after a cycle in which `pc_addr` differs from the breakpoint.
- R7: When bit 5 is set, a rising edge on `brk_async` is first seen at a clock edge through a two-stage synchronizer. `trap_req` is then high after the fourth rising clock edge counted from that one, for a single cycle.
- R8: While `in_handler` is 1, `trap_req` stays 0 in the following cycle. Step and address events seen in that time are not delivered later.
- R9: A break edge captured while `in_handler` is 1 stays pending. It is delivered as a one-cycle trap in the cycle after `in_handler` returns to 0.
- R10: A break edge that arrives while bit 5 is clear is discarded. Setting bit 5 afterwards produces no trap.
- R11: Word bits 31:28 and bit 7 have no effect on any trigger or on `pin_read_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Command word write strobe |
| cfg_wdata | input | 32 | Command word: breakpoint in 27:8, flags in 6:0 |
| pc_addr | input | 20 | Address of the current instruction |
| exec_ctx | input | 2 | Running context: 0 normal, 1..3 interrupt level |
| retire | input | 1 | Instruction retire strobe |
| in_handler | input | 1 | Debug handler is running |
| brk_async | input | 1 | Asynchronous break line |
| trap_req | output | 1 | One-cycle debug trap request |
| pin_read_mode | output | 1 | Stored mode bit: input reads return pin states |

## Verification
Each faulty piece of stored state shows up at `trap_req` within a few cycles. A wrong step-enable decode shows as a missing or extra pulse one cycle after a retire in the affected context. A stuck match-done flag either repeats the address trap on the next retire or suppresses it after the PC has left and come back. A break-pending flag that does not clear shows as a pulse lasting more than one cycle. One that is not held shows as a lost trap after the handler exits. The synchronizer depth is visible as the exact cycle in which the break pulse appears.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;
    localparam int CFG_W     = 32;
    localparam int N_CTX     = 4;
    localparam int CTX_W     = $clog2(N_CTX);
    localparam int FLAG_W    = 3 + N_CTX;
    localparam int BP_LSB    = 8;

    typedef struct packed {
        logic             pin_mode;
        logic             brk_en;
        logic             match_en;
        logic [N_CTX-1:0] step_en;
    } dbgt_flags_t;
endpackage

// File: rtl/dbgt_sync.sv
module dbgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dbgt_step_sel.sv
module dbgt_step_sel #(
    parameter int N_CTX = 4,
    localparam int CW   = $clog2(N_CTX)
) (
    input  logic [N_CTX-1:0] step_en,
    input  logic [CW-1:0]    ctx,
    output logic             sel_o
);
    logic [N_CTX-1:0] hit;

    for (genvar i = 0; i < N_CTX; i++) begin : g_ctx
        assign hit[i] = step_en[i] && (ctx == CW'(i));
    end

    assign sel_o = |hit;
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
    import dbgt_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic [CTX_W-1:0]  exec_ctx,
    input  logic              retire,
    input  logic              in_handler,
    input  logic              brk_async,
    output logic              trap_req,
    output logic              pin_read_mode
);
    localparam int BP_MSB = BP_LSB + ADDR_W - 1;

    typedef struct packed {
        dbgt_flags_t       flags;
        logic [ADDR_W-1:0] bp;
        logic              match_done;
        logic              brk_pend;
        logic              trap;
    } state_t;

    state_t s_d, s_q;
    logic   brk_rise;
    logic   step_sel;
    logic   addr_eq;
    logic   step_hit;
    logic   match_hit;
    logic   fire;
    logic   brk_pend_w;

    dbgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (brk_async),
        .rise_o   (brk_rise)
    );

    dbgt_step_sel #(.N_CTX(N_CTX)) u_step (
        .step_en (s_q.flags.step_en),
        .ctx     (exec_ctx),
        .sel_o   (step_sel)
    );

    always_comb begin
        s_d       = s_q;
        addr_eq   = (pc_addr == s_q.bp);
        step_hit  = retire && step_sel;
        match_hit = s_q.flags.match_en && retire && addr_eq && !s_q.match_done;
        fire      = !in_handler && (step_hit || match_hit || s_q.brk_pend);

        s_d.trap = fire;

        // address trap is one-shot per visit to the breakpoint
        if (!addr_eq)
            s_d.match_done = 1'b0;
        else if (retire && s_q.flags.match_en)
            s_d.match_done = 1'b1;

        // break edge is held until delivered
        if (fire)
            s_d.brk_pend = 1'b0;
        if (brk_rise && s_q.flags.brk_en)
            s_d.brk_pend = 1'b1;
        if (!s_q.flags.brk_en)
            s_d.brk_pend = 1'b0;

        if (cfg_we) begin
            s_d.flags      = dbgt_flags_t'(cfg_wdata[FLAG_W-1:0]);
            s_d.bp         = cfg_wdata[BP_MSB:BP_LSB];
            s_d.match_done = 1'b0;
            if (!cfg_wdata[5])
                s_d.brk_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trap_req      = s_q.trap;
    assign pin_read_mode = s_q.flags.pin_mode;
    assign brk_pend_w    = s_q.brk_pend;
endmodule

// File: rtl/dbg_trap_unit_chk.sv
module dbg_trap_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic mode_bit,
    input logic retire,
    input logic in_handler,
    input logic step_sel,
    input logic brk_pend,
    input logic trap_req,
    input logic pin_read_mode
);
    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (pin_read_mode == $past(mode_bit)));

    assert_step_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !in_handler && step_sel) |=> trap_req);

    assert_needs_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($past(retire) || $past(brk_pend)));

    assert_handler_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |=> !trap_req);

    assert_pending_delivered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend && !in_handler) |=> trap_req);
endmodule

bind dbg_trap_unit dbg_trap_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .mode_bit      (cfg_wdata[6]),
    .retire        (retire),
    .in_handler    (in_handler),
    .step_sel      (step_sel),
    .brk_pend      (brk_pend_w),
    .trap_req      (trap_req),
    .pin_read_mode (pin_read_mode)
);

// File: tb/dbg_trap_unit_tb.sv
module dbg_trap_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [19:0] pc_addr;
    logic [1:0]  exec_ctx;
    logic        retire;
    logic        in_handler;
    logic        brk_async;
    logic        trap_req;
    logic        pin_read_mode;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trap_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .pc_addr       (pc_addr),
        .exec_ctx      (exec_ctx),
        .retire        (retire),
        .in_handler    (in_handler),
        .brk_async     (brk_async),
        .trap_req      (trap_req),
        .pin_read_mode (pin_read_mode)
    );

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [31:0] w);
        cfg_we = 1'b1;
        cfg_wdata = w;
        cyc();
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    function automatic logic [31:0] word(logic [19:0] bp, logic [6:0] fl);
        return {4'h0, bp, 1'b0, fl};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [19:0] bp;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; pc_addr = '0;
        exec_ctx = '0; retire = 1'b0; in_handler = 1'b0; brk_async = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        check("R1 trap", trap_req, 1'b0);
        check("R1 mode", pin_read_mode, 1'b0);

        // R1: retire in every context at pc 0 plus a break edge, nothing armed
        retire = 1'b1; brk_async = 1'b1;
        for (int c = 0; c < 4; c++) begin
            exec_ctx = 2'(c);
            cyc();
            check("R1 idle", trap_req, 1'b0);
        end
        retire = 1'b0;
        for (int k = 0; k < 4; k++) begin cyc(); check("R1 idle", trap_req, 1'b0); end
        brk_async = 1'b0;
        cyc(3);

        // R2: mode bit follows writes
        wr(word(20'h0, 7'h40));
        check("R2 set", pin_read_mode, 1'b1);
        wr(word(20'h0, 7'h00));
        check("R2 clr", pin_read_mode, 1'b0);

        // R3 / R4: exhaustive step-enable x context sweep
        for (int p = 0; p < 16; p++) begin
            wr(word(20'hFFFFF, 7'(p)));
            for (int c = 0; c < 4; c++) begin
                exec_ctx = 2'(c);
                retire = 1'b1;
                cyc();
                check(p[c] ? "R3" : "R4", trap_req, p[c]);
                retire = 1'b0;
                cyc();
                check("R4 no retire", trap_req, 1'b0);
            end
        end

        // R5 / R6: address match over several breakpoints
        for (int i = 0; i < 4; i++) begin
            bp = 20'h5A5A5 ^ (20'h11111 * 20'(i));
            wr(word(bp, 7'h10));
            exec_ctx = 2'd0;
            pc_addr = bp; retire = 1'b0;
            cyc();
            check("R4 match no retire", trap_req, 1'b0);
            retire = 1'b1;
            cyc();
            check("R5", trap_req, 1'b1);
            cyc();
            check("R6 repeat", trap_req, 1'b0);
            pc_addr = bp + 20'd1;
            cyc();
            check("R5 mismatch", trap_req, 1'b0);
            pc_addr = bp;
            cyc();
            check("R6 rearm", trap_req, 1'b1);
            retire = 1'b0;
            cyc();
            check("R6 end", trap_req, 1'b0);
        end
        pc_addr = '0;

        // R8: handler suppresses step and match, not queued
        wr(word(20'h00123, 7'h1F));
        in_handler = 1'b1; retire = 1'b1; pc_addr = 20'h00123;
        for (int c = 0; c < 4; c++) begin
            exec_ctx = 2'(c);
            cyc();
            check("R8 blocked", trap_req, 1'b0);
        end
        retire = 1'b0; in_handler = 1'b0;
        cyc();
        check("R8 not queued", trap_req, 1'b0);
        cyc();
        check("R8 not queued", trap_req, 1'b0);
        pc_addr = '0;

        // R7: break timing
        wr(word(20'h0, 7'h20));
        brk_async = 1'b1;
        cyc(3);
        check("R7 early", trap_req, 1'b0);
        cyc();
        check("R7 fire", trap_req, 1'b1);
        cyc();
        check("R7 single", trap_req, 1'b0);
        cyc(2);
        check("R7 level no retrigger", trap_req, 1'b0);
        brk_async = 1'b0;
        cyc(3);

        // R9: break held across the handler
        in_handler = 1'b1;
        brk_async = 1'b1;
        for (int k = 0; k < 6; k++) begin cyc(); check("R9 held", trap_req, 1'b0); end
        in_handler = 1'b0;
        cyc();
        check("R9 deliver", trap_req, 1'b1);
        cyc();
        check("R9 single", trap_req, 1'b0);
        brk_async = 1'b0;
        cyc(3);

        // R10: edge while break disabled is dropped
        wr(word(20'h0, 7'h00));
        brk_async = 1'b1;
        cyc(5);
        wr(word(20'h0, 7'h20));
        for (int k = 0; k < 4; k++) begin cyc(); check("R10", trap_req, 1'b0); end
        brk_async = 1'b0;
        cyc(3);

        // R11: reserved bits have no effect
        bp = 20'h0ABCD;
        wr(word(bp, 7'h11) | 32'hF000_0080);
        check("R11 mode", pin_read_mode, 1'b0);
        pc_addr = bp; exec_ctx = 2'd1; retire = 1'b1;
        cyc();
        check("R11 match", trap_req, 1'b1);
        exec_ctx = 2'd0; pc_addr = bp + 20'd7;
        cyc();
        check("R11 step", trap_req, 1'b1);
        exec_ctx = 2'd2;
        cyc();
        check("R11 other ctx", trap_req, 1'b0);
        retire = 1'b0;
        cyc();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule